// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one memory burst. A start strobe captures a start column together with a burst length code, an ordering choice (counting or bit-flipping) and a device width setting. From the next clock on, it presents one column address per cycle and flags the final beat. The column bits inside the burst field change from beat to beat. The column bits above that field hold their start values. Column bits above the page width of the selected device width read as zero.

The same length code serves read and write bursts alike, so a command sequencer can use one generator for both directions. A page-length burst runs with counting order only. It sweeps the whole page, rolls over to column zero and keeps going until the stop input or a new start ends it. A settings combination the block cannot honour raises a flag and produces no beats. A new start strobe is accepted on any cycle and replaces whatever burst is in flight.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the cycle after it, col_valid, col_last and unsupported are all 0.
- R2: A start strobe sampled on a clock edge with supported settings makes col_valid 1 in the following cycle, and col_addr then shows the start column with bits at or above the page width cleared.
- R3: With ord_sel = 0 (counting), beat i carries low bits equal to (start low bits + i) modulo L, where L is 1, 2, 4 or 8 for len_code 0, 1, 2 or 3. For example, start 5 with L = 8 yields 5,6,7,0,1,2,3,4.
- R4: With ord_sel = 1 (bit-flip), beat i carries low bits equal to start low bits XOR i. For example, start 5 with L = 8 yields 5,4,7,6,1,0,3,2.
- R5: Column bits above the log2(L) burst field keep their start values for every beat of the burst.
- R6: A burst with len_code 0 to 3 presents exactly L beats, asserts col_last only on beat L-1 (on the only beat when L = 1), and drops col_valid afterwards unless a new start arrives.
- R7: len_code 7 with counting order gives a page burst over a page of 8, 9 or 10 column bits for dev_width 0, 1 or 2. It increments by one, rolls over from the top column to 0, never asserts col_last and runs until stopped.
- R8: stop sampled high on a clock edge while a beat is shown, with no start on that edge, makes col_valid 0 from the next cycle.
- R9: A start with len_code 7 and ord_sel = 1, or with len_code 4, 5 or 6, or with dev_width 3, sets unsupported to 1 and issues no beats. The flag holds until a start with supported settings clears it.
- R10: A start strobe during a running burst discards the rest of that burst, and the next cycle shows the first beat of the new one.
- R11: col_addr bits at or above the page width of the captured dev_width are 0 on every valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the settings below and begins a burst |
| start_col | input | 10 | First column of the burst |
| len_code | input | 3 | 0/1/2/3 = 1/2/4/8 beats, 7 = page, others reserved |
| ord_sel | input | 1 | 0 = counting order, 1 = bit-flip order |
| dev_width | input | 2 | 0 = 8-bit page, 1 = 9-bit, 2 = 10-bit, 3 reserved |
| stop | input | 1 | Ends the running burst |
| col_valid | output | 1 | A beat address is presented |
| col_addr | output | 10 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |
| unsupported | output | 1 | Last start carried settings that cannot be served |

## Verification
The bound checker watches several rules on every cycle. It checks the reset state and that the first beat equals the start column. It checks that no beat follows a final beat or a stop, and that the unsupported flag never coexists with a beat. It checks that page bursts never flag a last beat and that bits above the page width stay zero. Only the bench scenarios can show the full beat order: the counting and bit-flip sequences, the wrap points, the fixed upper bits, the page rollover past the top column and the exact point where an abort cuts a burst off. The bench shows these by comparing each beat against a queue of expected addresses built from the requirements.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;

    localparam int PAGE_MIN_BITS = 8;
    localparam int COL_MAX       = PAGE_MIN_BITS + 2;
    localparam int LEN_W         = 3;
    localparam int DEVW_W        = 2;

    typedef enum logic [LEN_W-1:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_e;

    typedef enum logic {
        ORD_COUNT = 1'b0,
        ORD_FLIP  = 1'b1
    } order_e;

    typedef struct packed {
        logic [COL_MAX-1:0] blk_mask;
        logic [COL_MAX-1:0] page_mask;
        logic               page_run;
        logic               bad;
    } burst_mode_t;

    function automatic logic [COL_MAX-1:0] page_mask_f(input logic [DEVW_W-1:0] w);
        logic [COL_MAX-1:0] m;
        m = '0;
        for (int b = 0; b < COL_MAX; b++) begin
            if (b < PAGE_MIN_BITS + int'(w)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/burst_mode_decode.sv
`timescale 1ns/1ps
module burst_mode_decode
    import burst_col_pkg::*;
(
    input  logic [LEN_W-1:0]  len_code,
    input  logic              ord_sel,
    input  logic [DEVW_W-1:0] dev_width,
    output burst_mode_t       mode
);
    localparam logic [DEVW_W-1:0] DEVW_RSVD = '1;

    always_comb begin
        mode           = '0;
        mode.page_mask = page_mask_f(dev_width);
        mode.bad       = (dev_width == DEVW_RSVD);
        case (len_e'(len_code))
            LEN_1:    mode.blk_mask = COL_MAX'(0);
            LEN_2:    mode.blk_mask = COL_MAX'(1);
            LEN_4:    mode.blk_mask = COL_MAX'(3);
            LEN_8:    mode.blk_mask = COL_MAX'(7);
            LEN_PAGE: begin
                mode.blk_mask = mode.page_mask;
                mode.page_run = 1'b1;
                if (order_e'(ord_sel) == ORD_FLIP) mode.bad = 1'b1;
            end
            default:  mode.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_addr_map.sv
`timescale 1ns/1ps
module burst_addr_map
    import burst_col_pkg::*;
(
    input  logic [COL_MAX-1:0] base_col,
    input  logic [COL_MAX-1:0] beat_idx,
    input  logic               ord_sel,
    input  burst_mode_t        mode,
    output logic [COL_MAX-1:0] addr
);
    logic [COL_MAX-1:0] moved;

    always_comb begin
        if (order_e'(ord_sel) == ORD_FLIP) moved = base_col ^ beat_idx;
        else                               moved = base_col + beat_idx;
    end

    for (genvar b = 0; b < COL_MAX; b++) begin : g_bit
        assign addr[b] = mode.page_mask[b] &
                         (mode.blk_mask[b] ? moved[b] : base_col[b]);
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
`timescale 1ns/1ps
module burst_beat_ctrl
    import burst_col_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COL_MAX-1:0] start_col,
    input  logic               ord_in,
    input  burst_mode_t        mode_in,
    input  logic               stop,
    output logic               active,
    output logic               at_last,
    output logic               unsup,
    output logic [COL_MAX-1:0] base_col,
    output logic [COL_MAX-1:0] beat_idx,
    output logic               ord_q,
    output burst_mode_t        mode_q
);
    assign at_last = !mode_q.page_run && (beat_idx == mode_q.blk_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            unsup    <= 1'b0;
            base_col <= '0;
            beat_idx <= '0;
            ord_q    <= 1'b0;
            mode_q   <= '0;
        end else if (start) begin
            base_col <= start_col;
            beat_idx <= '0;
            ord_q    <= ord_in;
            mode_q   <= mode_in;
            active   <= !mode_in.bad;
            unsup    <= mode_in.bad;
        end else if (active) begin
            if (stop || at_last) active <= 1'b0;
            else                 beat_idx <= beat_idx + 1'b1;
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = COL_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              ord_sel,
    input  logic [DEVW_W-1:0] dev_width,
    input  logic              stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_last,
    output logic              unsupported
);
    burst_mode_t        mode_d, mode_q;
    logic               active, at_last, ord_q;
    logic [COL_MAX-1:0] base_col, beat_idx, mapped;

    burst_mode_decode u_dec (
        .len_code (len_code),
        .ord_sel  (ord_sel),
        .dev_width(dev_width),
        .mode     (mode_d)
    );

    burst_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_col(COL_MAX'(start_col)),
        .ord_in   (ord_sel),
        .mode_in  (mode_d),
        .stop     (stop),
        .active   (active),
        .at_last  (at_last),
        .unsup    (unsupported),
        .base_col (base_col),
        .beat_idx (beat_idx),
        .ord_q    (ord_q),
        .mode_q   (mode_q)
    );

    burst_addr_map u_map (
        .base_col(base_col),
        .beat_idx(beat_idx),
        .ord_sel (ord_q),
        .mode    (mode_q),
        .addr    (mapped)
    );

    assign col_valid = active;
    assign col_last  = active & at_last;
    assign col_addr  = active ? COL_W'(mapped) : '0;
endmodule

// File: rtl/burst_col_chk.sv
`timescale 1ns/1ps
module burst_col_chk
    import burst_col_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [COL_MAX-1:0] start_col,
    input logic [LEN_W-1:0]   len_code,
    input logic [DEVW_W-1:0]  dev_width,
    input logic               stop,
    input logic               col_valid,
    input logic [COL_MAX-1:0] col_addr,
    input logic               col_last,
    input logic               unsupported
);
    logic               rst_seen;
    logic               lat_page;
    logic [COL_MAX-1:0] lat_pmask;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            lat_page  <= 1'b0;
            lat_pmask <= '0;
        end else if (start) begin
            lat_page  <= (len_code == LEN_PAGE);
            lat_pmask <= page_mask_f(dev_width);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_seen)
            assert_reset_quiet_R1: assert (!col_valid && !col_last && !unsupported);
    end

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (unsupported ||
                   (col_valid && col_addr == ($past(start_col) & page_mask_f($past(dev_width))))));

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_last && !start) |=> !col_valid);

    assert_page_no_last_R7: assert property (@(posedge clk) disable iff (rst)
        (col_valid && lat_page) |-> !col_last);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (col_valid && stop && !start) |=> !col_valid);

    assert_unsup_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> !col_valid);

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> ((col_addr & ~lat_pmask) == '0));
endmodule

bind burst_col_gen burst_col_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_col  (start_col),
    .len_code   (len_code),
    .dev_width  (dev_width),
    .stop       (stop),
    .col_valid  (col_valid),
    .col_addr   (col_addr),
    .col_last   (col_last),
    .unsupported(unsupported)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

    typedef struct {
        logic [9:0] addr;
        logic       last;
        string      tag;
    } beat_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ord_sel = 1'b0;
    logic [1:0] dev_width = '0;
    logic       stop = 1'b0;
    logic       col_valid, col_last, unsupported;
    logic [9:0] col_addr;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";
    beat_t exp_q[$];

    always #10 clk = ~clk;

    burst_col_gen dut (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .ord_sel(ord_sel), .dev_width(dev_width),
        .stop(stop), .col_valid(col_valid), .col_addr(col_addr),
        .col_last(col_last), .unsupported(unsupported)
    );

    function automatic beat_t model(input int col, input int lc, input int ord,
                                    input int dw, input int i, input string tag);
        beat_t r;
        int pm, len, lm, low;
        pm  = (1 << (8 + dw)) - 1;
        len = (lc == 7) ? (1 << (8 + dw)) : (1 << lc);
        lm  = len - 1;
        low = ord ? ((col & lm) ^ i) : (((col & lm) + i) & lm);
        r.addr = 10'(((col & ~lm) | low) & pm);
        r.last = (lc != 7) && (i == len - 1);
        r.tag  = tag;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && col_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected beat"}, int'(col_addr), -1);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(col_addr == e.addr, {e.tag, " addr"}, int'(col_addr), int'(e.addr));
                check(col_last == e.last, {e.tag, " last"}, int'(col_last), int'(e.last));
            end
        end
    end

    task automatic launch(input int col, input int lc, input int ord, input int dw,
                          input int nexp, input string tag);
        @(posedge clk); #1;
        start = 1'b1; start_col = 10'(col); len_code = 3'(lc);
        ord_sel = 1'(ord); dev_width = 2'(dw);
        @(posedge clk); #1;
        start = 1'b0;
        exp_q.delete();
        cur_tag = tag;
        for (int i = 0; i < nexp; i++) exp_q.push_back(model(col, lc, ord, dw, i, tag));
    endtask

    task automatic stop_after(input int n);
        repeat (n - 1) @(posedge clk);
        #1 stop = 1'b1;
        @(posedge clk); #1 stop = 1'b0;
    endtask

    task automatic drain(input string tag);
        int waited;
        waited = 0;
        while (exp_q.size() != 0 && waited < 2000) begin
            @(posedge clk); waited++;
        end
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " beats missing"}, exp_q.size(), 0);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!col_valid && !col_last && !unsupported, "R1 reset outputs",
              {col_valid, col_last, unsupported}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(!col_valid && !unsupported, "R1 after reset", {col_valid, unsupported}, 0);

        launch(5, 3, 0, 0, 8, "R2/R3 count len8 start5");   drain("R3");
        launch(5, 3, 1, 0, 8, "R4 flip len8 start5");       drain("R4");
        launch(10'h03A, 0, 0, 1, 1, "R6 len1");             drain("R6");
        launch(10'h1FF, 1, 1, 1, 2, "R4 flip len2");        drain("R4 len2");
        launch(10'h2D5, 2, 0, 2, 4, "R5 upper bits fixed"); drain("R5");
        launch(10'h3FF, 2, 0, 0, 4, "R11 upper page bits"); drain("R11");

        launch(10'h0FE, 7, 0, 0, 260, "R7 page 8-bit");
        stop_after(260); drain("R7 8-bit");
        launch(10'h1FE, 7, 0, 1, 4, "R7 page 9-bit");
        stop_after(4); drain("R7 9-bit");
        launch(10'h3FF, 7, 0, 2, 3, "R7 page 10-bit");
        stop_after(3); drain("R7 10-bit");

        launch(10'h013, 3, 0, 0, 3, "R8 stop finite");
        stop_after(3); drain("R8");

        launch(10'h020, 7, 1, 0, 0, "R9 page flip");
        check(unsupported == 1'b1, "R9 flag page flip", unsupported, 1);
        drain("R9 page flip");
        launch(10'h020, 5, 0, 0, 0, "R9 reserved len");
        check(unsupported == 1'b1, "R9 flag reserved len", unsupported, 1);
        drain("R9 len");
        launch(10'h020, 2, 0, 3, 0, "R9 reserved width");
        check(unsupported == 1'b1, "R9 flag reserved width", unsupported, 1);
        drain("R9 width");
        launch(10'h006, 2, 1, 0, 4, "R9 clear flag");
        check(unsupported == 1'b0, "R9 flag cleared", unsupported, 0);
        drain("R9 clear");

        launch(10'h044, 3, 0, 0, 8, "R10 first burst");
        launch(10'h0A3, 3, 1, 0, 8, "R10 restart");
        drain("R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule